// File: doc/BRIEF.md
# Multi-Lane Serial Pattern Generator

This block turns one 64-bit data word into several serial bit streams. The word is written through two 32-bit write ports: one port sets bits 0–31 and the other sets bits 32–63. Each write goes into a staging register. The staged value moves into the working register on the next step strobe taken while the block is running. The step strobe comes from an external clock divider. Each accepted strobe advances every lane by one bit position, so each pattern bit stays on its tap for exactly one strobe period.

A programmable bit length L sets the pattern period. L also splits the working register into equal lanes. Each lane is L rounded up to the next multiple of eight bits wide, and lanes start at bit 0. Eight fixed taps present bits 0, 8, 16 and so on up to 56. A per-tap valid flag marks which taps sit on the first bit of a complete lane. To give two outputs a phase offset, software loads the second lane with the same pattern shifted left by the offset.

Three advance modes are provided. Continuous rotation recirculates each lane forever. Rotate-once and shift-once each make a single pass of L strobes, raise a done flag and then freeze the lanes.

Top module: `lane_pattern_gen`

## Requirements
- R1: A pulse on `wr_lo_en` stores `wr_lo_data` into staging bits 0–31, and a pulse on `wr_hi_en` stores `wr_hi_data` into staging bits 32–63. The taps do not change until the staged value is loaded.
- R2: The first strobe (`run` and `step` both high at a clock edge) after any write copies the staging register into the working register. That strobe does not also advance the lanes, and it clears `done` and the pass counter.
- R3: `tap_out[k]` always equals working-register bit 8·k, for k = 0..7.
- R4: The effective length L is `bit_len`, where the value 0 means 64. Let B = ceil(L/8). The lane width is 8·B. `tap_valid[k]` is 1 exactly when k is a multiple of B and k+B ≤ 8.
- R5: `mode` 0 (continuous rotation) and `mode` 3 (treated the same way) advance every complete lane on each strobe. Lane bit p takes bit p+1 for p < L−1, and bit L−1 takes bit 0. The pattern repeats every L strobes, and `done` stays 0.
- R6: Lane bit positions at or above L are not moved by an advance and never enter positions below L. Register bits above the last complete lane also stay unchanged.
- R7: `mode` 1 (rotate once) rotates as in R5, but only for L advances. On the strobe that makes the L-th advance, `done` becomes 1. Later strobes leave the working register unchanged until a reload.
- R8: `mode` 2 (shift once) shifts each lane right and fills bit L−1 with 0. After L advances `done` becomes 1 and the lanes freeze as in R7.
- R9: A write made while running, including after `done`, takes effect on the next strobe. That strobe reloads the lanes and clears `done`.
- R10: A clock edge without both `run` and `step` high leaves the working register and the taps unchanged.
- R11: After reset the staging and working registers are 0, all taps are 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_lo_en | input | 1 | Write strobe for staging bits 0–31 |
| wr_lo_data | input | 32 | Data for staging bits 0–31 |
| wr_hi_en | input | 1 | Write strobe for staging bits 32–63 |
| wr_hi_data | input | 32 | Data for staging bits 32–63 |
| bit_len | input | 6 | Pattern length L; 0 means 64 |
| mode | input | 2 | 0/3 continuous rotate, 1 rotate once, 2 shift once |
| run | input | 1 | Generation enable |
| step | input | 1 | Advance strobe from the external divider |
| tap_out | output | 8 | Tap k carries working bit 8·k |
| tap_valid | output | 8 | Tap k is the first bit of a complete lane |
| done | output | 1 | A single-pass mode has completed |

## Verification
A fault in the working register shows on the taps no later than L strobes afterwards. Every lane bit passes through its lane's tap within one period, so a wrong bit or a wrong wrap point turns into a mismatched tap sequence within the first period. A wrong pass counter shows up as `done` rising one or more strobes early or late, or as taps that keep moving after `done`. A lost load-pending state shows on the very next strobe: the taps keep the old pattern instead of the staged one.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    typedef enum logic [1:0] {
        MODE_ROT_LOOP   = 2'd0,
        MODE_ROT_ONCE   = 2'd1,
        MODE_SHIFT_ONCE = 2'd2,
        MODE_ROT_LOOP_B = 2'd3
    } lpg_mode_e;

    function automatic logic is_single_pass(lpg_mode_e m);
        return (m == MODE_ROT_ONCE) || (m == MODE_SHIFT_ONCE);
    endfunction

    function automatic logic is_zero_fill(lpg_mode_e m);
        return m == MODE_SHIFT_ONCE;
    endfunction

endpackage

// File: rtl/lpg_lane_rot.sv
// One lane-width variant: advances every complete lane of width LANE_W
// over its first len bits; everything else holds.
module lpg_lane_rot #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    parameter int LEN_W  = 7
) (
    input  logic [DATA_W-1:0] din,
    input  logic [LEN_W-1:0]  len,
    input  logic              zero_fill,
    output logic [DATA_W-1:0] dout
);
    localparam int NUM_LANES = DATA_W / LANE_W;

    always_comb begin
        dout = din;
        for (int j = 0; j < NUM_LANES; j++) begin
            for (int p = 0; p < LANE_W; p++) begin
                if ((p < LANE_W - 1) && (p < int'(len) - 1)) begin
                    dout[j*LANE_W + p] = din[j*LANE_W + p + 1];
                end else if (p == int'(len) - 1) begin
                    dout[j*LANE_W + p] = zero_fill ? 1'b0 : din[j*LANE_W];
                end
            end
        end
    end

    // R5: a rotation keeps the number of ones when the length fits the lane
    always_comb begin
        if (!zero_fill && (int'(len) <= LANE_W) && (int'(len) > 0)) begin
            p_rot_keeps_ones_r5: assert ($countones(dout) == $countones(din));
        end
    end

endmodule

// File: rtl/lpg_advance.sv
// Builds every lane-width variant and selects the one for the current length.
module lpg_advance #(
    parameter int DATA_W = 64,
    parameter int STRIDE = 8,
    parameter int LEN_W  = 7,
    parameter int BW     = 4
) (
    input  logic [DATA_W-1:0] din,
    input  logic [LEN_W-1:0]  len_eff,
    input  logic [BW-1:0]     lane_bytes,
    input  logic              zero_fill,
    output logic [DATA_W-1:0] dout
);
    localparam int MAX_B = DATA_W / STRIDE;

    logic [DATA_W-1:0] cand [MAX_B];

    for (genvar g = 1; g <= MAX_B; g++) begin : g_width
        lpg_lane_rot #(
            .DATA_W (DATA_W),
            .LANE_W (g * STRIDE),
            .LEN_W  (LEN_W)
        ) u_rot (
            .din       (din),
            .len       (len_eff),
            .zero_fill (zero_fill),
            .dout      (cand[g-1])
        );
    end

    always_comb begin
        dout = din;
        for (int i = 0; i < MAX_B; i++) begin
            if (int'(lane_bytes) == i + 1) dout = cand[i];
        end
    end

endmodule

// File: rtl/lpg_tap_map.sv
// Fixed taps at every STRIDE-th bit plus lane-start validity flags.
module lpg_tap_map #(
    parameter int NUM_TAPS = 8,
    parameter int STRIDE   = 8,
    parameter int BW       = 4
) (
    input  logic [NUM_TAPS*STRIDE-1:0] work,
    input  logic [BW-1:0]              lane_bytes,
    output logic [NUM_TAPS-1:0]        tap_out,
    output logic [NUM_TAPS-1:0]        tap_valid
);
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign tap_out[k] = work[k*STRIDE];
        always_comb begin
            if (lane_bytes == '0) begin
                tap_valid[k] = 1'b0;
            end else begin
                tap_valid[k] = ((k % int'(lane_bytes)) == 0) &&
                               (k + int'(lane_bytes) <= NUM_TAPS);
            end
        end
    end

endmodule

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen
    import lpg_pkg::*;
#(
    parameter int TAP_STRIDE = 8,
    parameter int NUM_TAPS   = 8,
    localparam int DATA_W    = NUM_TAPS * TAP_STRIDE,
    localparam int WORD_W    = DATA_W / 2,
    localparam int CFG_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo_en,
    input  logic [WORD_W-1:0] wr_lo_data,
    input  logic              wr_hi_en,
    input  logic [WORD_W-1:0] wr_hi_data,
    input  logic [CFG_W-1:0]  bit_len,
    input  logic [1:0]        mode,
    input  logic              run,
    input  logic              step,
    output logic [NUM_TAPS-1:0] tap_out,
    output logic [NUM_TAPS-1:0] tap_valid,
    output logic              done
);
    localparam int LEN_W = CFG_W + 1;
    localparam int BW    = $clog2(NUM_TAPS + 1);

    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] work;
        logic              pend;
        logic [LEN_W-1:0]  cnt;
        logic              done;
    } lpg_state_t;

    lpg_state_t st_d, st_q;

    lpg_mode_e         mode_e;
    logic [LEN_W-1:0]  len_eff;
    logic [LEN_W:0]    lb_wide;
    logic [BW-1:0]     lane_bytes;
    logic [DATA_W-1:0] work_adv;
    logic              fire;
    logic [LEN_W-1:0]  cnt_inc;

    assign mode_e     = lpg_mode_e'(mode);
    assign len_eff    = (bit_len == '0) ? LEN_W'(DATA_W) : LEN_W'(bit_len);
    assign lb_wide    = ({1'b0, len_eff} + (LEN_W+1)'(TAP_STRIDE - 1)) / (LEN_W+1)'(TAP_STRIDE);
    assign lane_bytes = BW'(lb_wide);
    assign fire       = run && step;
    assign cnt_inc    = st_q.cnt + LEN_W'(1);

    lpg_advance #(
        .DATA_W (DATA_W),
        .STRIDE (TAP_STRIDE),
        .LEN_W  (LEN_W),
        .BW     (BW)
    ) u_adv (
        .din        (st_q.work),
        .len_eff    (len_eff),
        .lane_bytes (lane_bytes),
        .zero_fill  (is_zero_fill(mode_e)),
        .dout       (work_adv)
    );

    lpg_tap_map #(
        .NUM_TAPS (NUM_TAPS),
        .STRIDE   (TAP_STRIDE),
        .BW       (BW)
    ) u_taps (
        .work       (st_q.work),
        .lane_bytes (lane_bytes),
        .tap_out    (tap_out),
        .tap_valid  (tap_valid)
    );

    always_comb begin
        st_d = st_q;
        if (wr_lo_en) st_d.stage[WORD_W-1:0]      = wr_lo_data;
        if (wr_hi_en) st_d.stage[DATA_W-1:WORD_W] = wr_hi_data;
        if (fire) begin
            if (st_q.pend) begin
                st_d.work = st_q.stage;
                st_d.cnt  = '0;
                st_d.done = 1'b0;
            end else if (!st_q.done) begin
                st_d.work = work_adv;
                if (is_single_pass(mode_e)) begin
                    st_d.cnt = cnt_inc;
                    if (cnt_inc == len_eff) st_d.done = 1'b1;
                end
            end
        end
        st_d.pend = (fire ? 1'b0 : st_q.pend) | wr_lo_en | wr_hi_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;

    // R10: no accepted strobe, no movement of the working register
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && step) |=> $stable(st_q.work));

    // R2: a strobe with a pending write loads the staged word and clears done
    p_load_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && st_q.pend) |=> (st_q.work == $past(st_q.stage)) && !st_q.done);

    // R7: done only rises under a single-pass mode
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> ($past(mode) == 2'd1 || $past(mode) == 2'd2));

    // R7/R8: once done, lanes freeze until a reload is pending
    p_done_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !st_q.pend) |=> $stable(st_q.work));

endmodule

// File: tb/tb_lane_pattern_gen.sv
module tb_lane_pattern_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_lo_en = 1'b0;
    logic [31:0] wr_lo_data = '0;
    logic        wr_hi_en = 1'b0;
    logic [31:0] wr_hi_data = '0;
    logic [5:0]  bit_len = 6'd10;
    logic [1:0]  mode = 2'd0;
    logic        run = 1'b0;
    logic        step = 1'b0;
    logic [7:0]  tap_out;
    logic [7:0]  tap_valid;
    logic        done;

    always #5 clk = ~clk;

    lane_pattern_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo_en   (wr_lo_en),
        .wr_lo_data (wr_lo_data),
        .wr_hi_en   (wr_hi_en),
        .wr_hi_data (wr_hi_data),
        .bit_len    (bit_len),
        .mode       (mode),
        .run        (run),
        .step       (step),
        .tap_out    (tap_out),
        .tap_valid  (tap_valid),
        .done       (done)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference model state
    logic [63:0] m_stage = '0;
    logic [63:0] m_work  = '0;
    bit          m_pend  = 0;
    bit          m_done  = 0;
    int          m_cnt   = 0;

    // scoreboard queues
    logic [7:0] q_tap[$];
    logic       q_done[$];
    string      q_tag[$];

    function automatic int eff_len(logic [5:0] b);
        return (b == 6'd0) ? 64 : int'(b);
    endfunction

    function automatic logic [63:0] model_adv(logic [63:0] v, int len, bit zf);
        int w = 8 * ((len + 7) / 8);
        int n = 64 / w;
        logic [63:0] r = v;
        for (int j = 0; j < n; j++) begin
            for (int p = 0; p < len; p++) begin
                if (p < len - 1) r[j*w + p] = v[j*w + p + 1];
                else             r[j*w + p] = zf ? 1'b0 : v[j*w];
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] taps_of(logic [63:0] v);
        logic [7:0] t;
        for (int k = 0; k < 8; k++) t[k] = v[8*k];
        return t;
    endfunction

    function automatic logic [7:0] valid_of(int len);
        int b = (len + 7) / 8;
        logic [7:0] t;
        for (int k = 0; k < 8; k++) t[k] = ((k % b) == 0) && (k + b <= 8);
        return t;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares design outputs with expected items after each strobe
    always @(negedge clk) begin
        logic [7:0] et;
        logic       ed;
        string      es;
        while (q_tap.size() > 0) begin
            et = q_tap.pop_front();
            ed = q_done.pop_front();
            es = q_tag.pop_front();
            check({es, " tap_out"}, 64'(tap_out), 64'(et));
            check({es, " done"}, 64'(done), 64'(ed));
        end
    end

    // driver: one step pulse, model update, expected item pushed
    task automatic strobe(string tag);
        int  len;
        bit  once;
        @(negedge clk);
        step = 1'b1;
        @(posedge clk);
        len  = eff_len(bit_len);
        once = (mode == 2'd1) || (mode == 2'd2);
        if (run) begin
            if (m_pend) begin
                m_work = m_stage;
                m_cnt  = 0;
                m_done = 0;
                m_pend = 0;
            end else if (!m_done) begin
                m_work = model_adv(m_work, len, mode == 2'd2);
                if (once) begin
                    m_cnt++;
                    if (m_cnt == len) m_done = 1;
                end
            end
        end
        q_tap.push_back(taps_of(m_work));
        q_done.push_back(m_done);
        q_tag.push_back(tag);
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic write_word(bit hi, logic [31:0] v);
        @(negedge clk);
        if (hi) begin wr_hi_en = 1'b1; wr_hi_data = v; end
        else    begin wr_lo_en = 1'b1; wr_lo_data = v; end
        @(negedge clk);
        wr_hi_en = 1'b0;
        wr_lo_en = 1'b0;
        if (hi) m_stage[63:32] = v;
        else    m_stage[31:0]  = v;
        m_pend = 1;
    endtask

    task automatic load_both(logic [31:0] lo, logic [31:0] hi);
        write_word(0, lo);
        write_word(1, hi);
    endtask

    task automatic check_len_valid(logic [5:0] b);
        @(negedge clk);
        bit_len = b;
        #1;
        check($sformatf("R4 tap_valid len=%0d", eff_len(b)), 64'(tap_valid), 64'(valid_of(eff_len(b))));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset taps", 64'(tap_out), 64'h0);
        check("R11 reset done", 64'(done), 64'h0);

        // R4: lane partitioning flags
        check_len_valid(6'd8);
        check_len_valid(6'd10);
        check_len_valid(6'd20);
        check_len_valid(6'd32);
        check_len_valid(6'd40);
        check_len_valid(6'd0);
        check_len_valid(6'd3);

        // R1, R2, R5: two streams offset by two bits, length 10
        @(negedge clk);
        bit_len = 6'd10;
        mode    = 2'd0;
        run     = 1'b1;
        load_both(32'h007C_001F, 32'h0000_0000);
        @(negedge clk);
        check("R1 taps unchanged before load", 64'(tap_out), 64'h0);
        strobe("R2 load");
        for (int i = 0; i < 24; i++) strobe("R5 continuous rotate len10");

        // R6: bits above the length never reach the taps
        load_both(32'hFC00_FC00, 32'h0000_0000);
        strobe("R6 load");
        for (int i = 0; i < 12; i++) strobe("R6 upper lane bits ignored");

        // R3, R1: eight independent lanes with high-word data
        @(negedge clk);
        bit_len = 6'd8;
        load_both(32'hA5C3_0F81, 32'h3C66_F00D);
        strobe("R1 high word load");
        for (int i = 0; i < 17; i++) strobe("R3 eight lanes");

        // R10: run low, then no strobe
        @(negedge clk);
        run = 1'b0;
        for (int i = 0; i < 3; i++) strobe("R10 run low");
        @(negedge clk);
        run = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 no strobe hold", 64'(tap_out), 64'(taps_of(m_work)));

        // R9: write while running reloads on next strobe
        write_word(0, 32'h1111_1111);
        strobe("R9 reload while running");
        for (int i = 0; i < 3; i++) strobe("R9 after reload");

        // R7: rotate once, length 5
        @(negedge clk);
        bit_len = 6'd5;
        mode    = 2'd1;
        load_both(32'h1A0B_1C0D, 32'h0E13_1F07);
        strobe("R7 load");
        for (int i = 0; i < 8; i++) strobe("R7 rotate once");

        // R9: reload after done clears done
        write_word(0, 32'h0302_0104);
        strobe("R9 reload clears done");

        // R8: shift once, length 20
        @(negedge clk);
        bit_len = 6'd20;
        mode    = 2'd2;
        load_both(32'hFFFF_FFFF, 32'h0000_0FFF);
        strobe("R8 load");
        for (int i = 0; i < 23; i++) strobe("R8 shift once");

        // R5: mode 3 behaves as continuous rotate
        @(negedge clk);
        bit_len = 6'd12;
        mode    = 2'd3;
        load_both(32'h0805_0A37, 32'h0C01_0E09);
        strobe("R5 mode3 load");
        for (int i = 0; i < 14; i++) strobe("R5 mode3 loops");

        // R4: length 0 means 64, single lane
        @(negedge clk);
        bit_len = 6'd0;
        mode    = 2'd0;
        load_both(32'h8000_0001, 32'h0000_0100);
        strobe("R4 full length load");
        for (int i = 0; i < 10; i++) strobe("R4 full length rotate");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule